// File: doc/BRIEF.md
# DDR3 Mode Register Power-Up Sequencer

This block brings one DDR3 rank out of its power-up state by programming its four mode registers and then running a long ZQ calibration. A single start pulse, together with a chip-select index, launches the run. The block then emits five commands on a valid/ready command port. The first four are load-mode-register commands, each carrying a register index and a 16-bit value. The fifth is a ZQ calibration long command. Every command carries the chip-select that was captured at the start.

Commands are spaced by the mode-register-set delay. After the calibration command is accepted, the block waits out the ZQ initialisation time and then pulses `done`. A board with two ranks runs the sequencer twice: first for select 0, then for select 1. Reset and clock-enable timing, refresh and data traffic are handled elsewhere.

The register values come from parameters: CAS latency, CAS write latency and write recovery. The remaining fields are fixed: drive strength RZQ/7, nominal termination RZQ/2, additive latency off, dynamic ODT off, MPR off, fixed burst length 8, nibble-sequential burst order, slow-exit precharge power-down, and DLL reset requested.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: After a synchronous active-low reset, `cmd_valid`, `busy` and `done` are all 0.
- R2: A run issues exactly five commands in this order: MR2, MR3, MR1, MR0, then ZQ calibration long. `cmd_kind` is 2'b01 for a mode register load and 2'b10 for ZQ calibration long. `cmd_mr` carries the register index (2, 3, 1, 0) and is 0 for the ZQ command. The ZQ command value is 16'h0400, which sets address bit 10 for the long form.
- R3: With default parameters, MR2 carries 16'h0000 and MR3 carries 16'h0000. In MR2, CWL-5 is encoded in bits 5:3.
- R4: MR1 carries 16'h0042. Bit 1 set selects drive RZQ/7. Bit 6 set, with bits 9 and 2 clear, selects RTT_nom RZQ/2. Bits 4:3 are clear for additive latency off.
- R5: With default parameters, MR0 carries 16'h0520. CL-4 sits in bits 6:4 (010 for CL 6). Bit 8 set requests DLL reset. The write recovery code sits in bits 11:9 (010 for WR 6). Bits 12, 3 and 1:0 are clear.
- R6: Every command of a run carries on `cmd_cs` the `cs_sel` value sampled with `start`. A `start` pulse while `busy` is 1 has no effect, and no new run begins after `done`.
- R7: The first command is valid in the cycle after the `start` cycle. Each later command becomes valid exactly TMRD cycles (default 4) after the cycle in which the previous command was accepted. `cmd_valid` stays 0 in between, even when `cmd_ready` is held high.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, the command and all of its fields hold unchanged.
- R9: `done` is a single-cycle pulse exactly TZQINIT cycles (default 512) after the cycle in which the ZQ command was accepted. `busy` is 0 in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| cs_sel | input | CS_W | Chip-select for the run, sampled with start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_kind | output | 2 | 01 load mode register, 10 ZQ calibration long |
| cmd_mr | output | 2 | Mode register index |
| cmd_value | output | 16 | Mode register / address value |
| cmd_cs | output | CS_W | Target chip-select |

## Verification
The bench targets the ordering and field encodings of all five commands. A swapped step, or a field placed at the wrong bit, shows up as a wrong `cmd_mr` or `cmd_value`. Spacing is measured from the accepting cycle, both with the consumer stalling and with `cmd_ready` held high throughout. A design that counted from the first valid cycle, or that re-issued during the gap, would therefore show early or extra commands. A `start` pulse is injected mid-run with the other chip-select, and the select input is toggled after launch. A design that relaunched or tracked the live input would then emit the wrong `cmd_cs` or restart after `done`. The `done` cycle is checked exactly, which catches an off-by-one in the ZQ wait.

// File: rtl/mrs_seq_pkg.sv
// Package: shared types and DDR3 mode-register field encoders for the
// power-up sequencer. Assumes legal DDR3 CL (5..11), CWL (5..8), WR.
package mrs_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_LMR  = 2'b01,
        CMD_ZQCL = 2'b10
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_ZQWAIT
    } seq_state_e;

    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = 3;
    localparam logic [15:0] ZQCL_ADDR = 16'h0400;

    // CWL code: CWL-5 in three bits
    function automatic logic [2:0] cwl_field(input int cwl);
        return 3'(cwl - 5);
    endfunction

    // CL code for bits 6:4 (bit 2 kept clear for CL up to 11)
    function automatic logic [2:0] cl_field(input int cl);
        return 3'(cl - 4);
    endfunction

    // Write recovery code for bits 11:9
    function automatic logic [2:0] wr_field(input int wr);
        if (wr <= 8)
            return 3'(wr - 4);
        else if (wr < 16)
            return 3'(wr / 2);
        else
            return 3'd0;
    endfunction

    // MR0: fixed BL8, nibble order, DLL reset, slow-exit PPD
    function automatic logic [15:0] mr0_value(input int cl, input int wr);
        logic [15:0] v;
        v        = 16'h0000;
        v[6:4]   = cl_field(cl);
        v[8]     = 1'b1;
        v[11:9]  = wr_field(wr);
        return v;
    endfunction

    // MR1: drive RZQ/7, RTT_nom RZQ/2, additive latency off, DLL on
    function automatic logic [15:0] mr1_value();
        logic [15:0] v;
        v    = 16'h0000;
        v[1] = 1'b1;
        v[6] = 1'b1;
        return v;
    endfunction

    // MR2: CWL field, dynamic ODT off, normal temp, full-array refresh
    function automatic logic [15:0] mr2_value(input int cwl);
        logic [15:0] v;
        v      = 16'h0000;
        v[5:3] = cwl_field(cwl);
        return v;
    endfunction

endpackage

// File: rtl/mrs_cmd_table.sv
// Module: maps a sequence step to the command it issues.
// Assumes step values 0..4; anything above yields an idle code.
module mrs_cmd_table
    import mrs_seq_pkg::*;
#(
    parameter int CAS_LAT = 6,
    parameter int CWL     = 5,
    parameter int WR_REC  = 6
) (
    input  logic [STEP_W-1:0] step,
    output logic [1:0]        kind,
    output logic [1:0]        mr,
    output logic [15:0]       value
);

    localparam logic [15:0] MR0_V = mr0_value(CAS_LAT, WR_REC);
    localparam logic [15:0] MR1_V = mr1_value();
    localparam logic [15:0] MR2_V = mr2_value(CWL);
    localparam logic [15:0] MR3_V = 16'h0000;

    // Step decode: fixed load order MR2, MR3, MR1, MR0, then ZQCL
    always_comb begin
        kind  = CMD_LMR;
        mr    = 2'd0;
        value = 16'h0000;
        case (step)
            3'd0: begin mr = 2'd2; value = MR2_V; end
            3'd1: begin mr = 2'd3; value = MR3_V; end
            3'd2: begin mr = 2'd1; value = MR1_V; end
            3'd3: begin mr = 2'd0; value = MR0_V; end
            3'd4: begin kind = CMD_ZQCL; value = ZQCL_ADDR; end
            default: kind = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/mrs_wait_timer.sv
// Module: down-counter shared by the inter-command gap and the ZQ wait.
// Assumes load values of at least 1; flags the final counted cycle.
module mrs_wait_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/mrs_seq_ctrl.sv
// Module: run controller. Captures the chip-select, steps through the
// five commands under the valid/ready handshake and times gaps and the
// ZQ wait through the shared timer. Assumes TMRD >= 1, TZQINIT >= 2.
module mrs_seq_ctrl
    import mrs_seq_pkg::*;
#(
    parameter int TMRD    = 4,
    parameter int TZQINIT = 512,
    parameter int CS_W    = 1,
    parameter int CNT_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CS_W-1:0]   cs_sel,
    input  logic              cmd_ready,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [STEP_W-1:0] step,
    output logic [CS_W-1:0]   cs_q,
    output logic              cmd_valid,
    output logic              busy,
    output logic              done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam bit                HAS_GAP   = (TMRD > 1);

    seq_state_e state;
    logic       accept;

    assign cmd_valid = (state == ST_ISSUE);
    assign busy      = (state != ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    // Timer load on every accepted command: gap or ZQ wait length
    assign tmr_load = accept;
    assign tmr_val  = (step == LAST_STEP) ? CNT_W'(TZQINIT - 1)
                                          : CNT_W'(TMRD - 1);

    // Sequence state, step index, captured select and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            cs_q  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cs_q  <= cs_sel;
                        step  <= '0;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        if (step == LAST_STEP) begin
                            state <= ST_ZQWAIT;
                        end else begin
                            step  <= step + 1'b1;
                            state <= HAS_GAP ? ST_GAP : ST_ISSUE;
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_last)
                        state <= ST_ISSUE;
                end
                ST_ZQWAIT: begin
                    if (tmr_last) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ddr3_mrs_seq.sv
// Module: top of the DDR3 mode-register power-up sequencer. Issues
// MR2, MR3, MR1, MR0 loads and a ZQ calibration long to one rank,
// spaced by TMRD, then pulses done after TZQINIT cycles.
// Assumes the consumer honours the valid/ready handshake.
module ddr3_mrs_seq
    import mrs_seq_pkg::*;
#(
    parameter int TMRD    = 4,
    parameter int TZQINIT = 512,
    parameter int CAS_LAT = 6,
    parameter int CWL     = 5,
    parameter int WR_REC  = 6,
    parameter int CS_W    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CS_W-1:0] cs_sel,
    output logic            busy,
    output logic            done,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [1:0]      cmd_kind,
    output logic [1:0]      cmd_mr,
    output logic [15:0]     cmd_value,
    output logic [CS_W-1:0] cmd_cs
);

    localparam int MAX_WAIT = (TZQINIT > TMRD) ? TZQINIT : TMRD;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic              tmr_load;
    logic              tmr_last;
    logic [CNT_W-1:0]  tmr_val;
    logic [STEP_W-1:0] step;

    mrs_seq_ctrl #(
        .TMRD    (TMRD),
        .TZQINIT (TZQINIT),
        .CS_W    (CS_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cs_sel    (cs_sel),
        .cmd_ready (cmd_ready),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .step      (step),
        .cs_q      (cmd_cs),
        .cmd_valid (cmd_valid),
        .busy      (busy),
        .done      (done)
    );

    mrs_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    mrs_cmd_table #(
        .CAS_LAT (CAS_LAT),
        .CWL     (CWL),
        .WR_REC  (WR_REC)
    ) u_table (
        .step  (step),
        .kind  (cmd_kind),
        .mr    (cmd_mr),
        .value (cmd_value)
    );

endmodule

// File: rtl/mrs_seq_checker.sv
// Module: protocol checker for ddr3_mrs_seq, bound to the top.
// Measures handshake spacing and the ZQ wait with its own counter.
module mrs_seq_checker #(
    parameter int TMRD    = 4,
    parameter int TZQINIT = 512,
    parameter int CS_W    = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_kind,
    input logic [1:0]      cmd_mr,
    input logic [15:0]     cmd_value,
    input logic [CS_W-1:0] cmd_cs
);

    localparam int LIM = TZQINIT + TMRD + 1;
    localparam int SW  = $clog2(LIM + 1);

    logic [SW-1:0] since;
    logic          seen_hs;
    logic          zq_seen;

    // Cycles since the last accepted command, per run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= '0;
            seen_hs <= 1'b0;
            zq_seen <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            since   <= SW'(1);
            seen_hs <= 1'b1;
            zq_seen <= (cmd_kind == 2'b10);
        end else if (done) begin
            seen_hs <= 1'b0;
            zq_seen <= 1'b0;
        end else if (since < SW'(LIM)) begin
            since <= since + 1'b1;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
        $stable(cmd_mr) && $stable(cmd_value) && $stable(cmd_cs));

    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && seen_hs |-> since >= SW'(TMRD));

    p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind == 2'b01 || cmd_kind == 2'b10));

    p_cs_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cmd_cs));

    p_done_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> zq_seen && since == SW'(TZQINIT) && !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind ddr3_mrs_seq mrs_seq_checker #(
    .TMRD    (TMRD),
    .TZQINIT (TZQINIT),
    .CS_W    (CS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_mr    (cmd_mr),
    .cmd_value (cmd_value),
    .cmd_cs    (cmd_cs)
);

// File: tb/sim_ddr3_mrs_seq.sv
// Directed bench for ddr3_mrs_seq: one task per scenario, each self-checking.
module sim_ddr3_mrs_seq;

    localparam int TMRD    = 4;
    localparam int TZQ     = 512;
    localparam int WD_LIM  = 20000;
    localparam logic [15:0] E_MR2 = 16'((5 - 5) << 3);
    localparam logic [15:0] E_MR3 = 16'h0000;
    localparam logic [15:0] E_MR1 = 16'h0002 | 16'h0040;
    localparam logic [15:0] E_MR0 = 16'(2 << 4) | 16'(1 << 8) | 16'(2 << 9);
    localparam logic [15:0] E_ZQ  = 16'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [0:0]  cs_sel = 1'b0;
    logic        busy, done, cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_kind, cmd_mr;
    logic [15:0] cmd_value;
    logic [0:0]  cmd_cs;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIM) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIM);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    ddr3_mrs_seq #(.TMRD(TMRD), .TZQINIT(TZQ)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cs_sel(cs_sel),
        .busy(busy), .done(done), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_mr(cmd_mr),
        .cmd_value(cmd_value), .cmd_cs(cmd_cs)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reset state (R1)
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "cmd_valid in reset", 32'(cmd_valid), 0);
        chk("R1", "busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", 32'(done), 0);
        chk("R1", "busy after reset", 32'(busy), 0);
    endtask

    // One full run: stall cycles per command, optional ready held high,
    // optional mid-run start with the other select (R2..R9)
    task automatic t_run(input logic cs, input int stall,
                         input bit pre_ready, input bit intrude);
        int exp_t;
        int hs;
        int n;
        logic [1:0]  e_mr;
        logic [15:0] e_val;
        logic [1:0]  e_kind;
        @(negedge clk);
        cs_sel = cs;
        start  = 1'b1;
        exp_t  = cyc + 1;
        @(negedge clk);
        start  = 1'b0;
        cs_sel = ~cs;
        cmd_ready = pre_ready;
        hs = 0;
        for (int i = 0; i < 5; i++) begin
            n = 0;
            while (!cmd_valid && n < 64) begin
                @(negedge clk);
                n++;
            end
            case (i)
                0: begin e_mr = 2'd2; e_val = E_MR2; end
                1: begin e_mr = 2'd3; e_val = E_MR3; end
                2: begin e_mr = 2'd1; e_val = E_MR1; end
                3: begin e_mr = 2'd0; e_val = E_MR0; end
                default: begin e_mr = 2'd0; e_val = E_ZQ; end
            endcase
            e_kind = (i == 4) ? 2'b10 : 2'b01;
            chk("R7", "command valid cycle", 32'(cyc), 32'(exp_t));
            chk("R2", "command kind", 32'(cmd_kind), 32'(e_kind));
            chk("R2", "register index", 32'(cmd_mr), 32'(e_mr));
            case (i)
                0, 1: chk("R3", "MR2/MR3 value", 32'(cmd_value), 32'(e_val));
                2:    chk("R4", "MR1 value", 32'(cmd_value), 32'(e_val));
                3:    chk("R5", "MR0 value", 32'(cmd_value), 32'(e_val));
                default: chk("R2", "ZQCL value", 32'(cmd_value), 32'(e_val));
            endcase
            chk("R6", "chip-select", 32'(cmd_cs), 32'(cs));
            if (!pre_ready) begin
                for (int k = 0; k < stall; k++) begin
                    if (intrude && i == 2 && k == 0) begin
                        start = 1'b1;
                        cs_sel = ~cs;
                    end
                    @(negedge clk);
                    start = 1'b0;
                    chk("R8", "valid held", 32'(cmd_valid), 1);
                    chk("R8", "value held", 32'(cmd_value), 32'(e_val));
                    chk("R6", "select held during stall", 32'(cmd_cs), 32'(cs));
                end
                cmd_ready = 1'b1;
                hs = cyc;
                @(negedge clk);
                cmd_ready = 1'b0;
            end else begin
                hs = cyc;
                @(negedge clk);
            end
            if (i < 4)
                chk("R7", "valid low in gap", 32'(cmd_valid), 0);
            exp_t = hs + TMRD;
        end
        n = 0;
        while (!done && n < TZQ + 20) begin
            @(negedge clk);
            n++;
        end
        cmd_ready = 1'b0;
        chk("R9", "done cycle", 32'(cyc), 32'(hs + TZQ));
        chk("R9", "busy low at done", 32'(busy), 0);
        @(negedge clk);
        chk("R9", "done single pulse", 32'(done), 0);
        chk("R6", "no relaunch after done", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R6", "idle stays idle", 32'(cmd_valid), 0);
    endtask

    initial begin
        t_reset();
        t_run(1'b0, 0, 1'b0, 1'b0);
        t_run(1'b1, 0, 1'b0, 1'b0);
        t_run(1'b0, 3, 1'b0, 1'b1);
        t_run(1'b1, 0, 1'b1, 1'b0);
        t_run(1'b1, 2, 1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule